// File: doc/BRIEF.md
# System Peripheral Space Router

This block decodes accesses to the 1 MB system peripheral space, which starts at 0xE000_0000, and steers each one to a single destination. The destinations are a system-register block, one of two banked tick-timer register sets, an optional error-reporting register block, or a built-in default responder. When regions overlap, a fixed priority picks the winner: the timer window beats the system-register page, and any real region beats the default responder.

A second page in the space holds an alias of the system-register page, with a timer alias inside it. The alias lets secure software reach the non-secure copies of the banked registers. A secure access to the alias is sent to the main region with its secure attribute cleared. A non-secure access to the alias is answered locally. An enable input turns both alias windows on or off.

Decode and forwarding are fully combinational. An access that is valid in a cycle gets its response in that same cycle, from the selected target or from the local responder.

Top module: `ppb_router`

## Requirements
- R1: An access whose offset lies in page 0x0E000–0x0EFFF, outside the timer window, asserts `sel_sys`. It forwards `tgt_addr` = offset[11:0] and `tgt_secure` = `req_secure`.
- R2: An access whose page offset lies in 0x010–0x0EF of page 0x0E takes priority over the system-register page. It selects `sel_tmr_s` when `req_secure`=1 and `sel_tmr_ns` otherwise. It forwards `tgt_addr` = page offset − 0x010 and `tgt_secure` = `req_secure`.
- R3: An access to an unclaimed offset selects no target and returns `rsp_rdata` = 0. It returns `rsp_err` = 0 when `req_priv`=1 and `rsp_err` = 1 when `req_priv`=0.
- R4: When HAS_ERR_BLK=1, page 0x05000–0x05FFF asserts `sel_errblk` with `tgt_addr` = offset[11:0] and `tgt_secure` = `req_secure`.
- R5: With `sec_ext_en`=1, a secure access to alias page 0x2E000–0x2EFFF outside its timer window asserts `sel_sys`, with `tgt_secure`=0 and `tgt_addr` = offset[11:0].
- R6: With `sec_ext_en`=1, a secure access to page offsets 0x010–0x0EF of the alias page selects `sel_tmr_ns`, with `tgt_secure`=0 and `tgt_addr` = page offset − 0x010.
- R7: With `sec_ext_en`=1, a non-secure access anywhere in the alias page selects no target and returns `rsp_rdata` = 0. It returns `rsp_err` = 0 if privileged and 1 if user.
- R8: With `sec_ext_en`=0, alias-page offsets behave exactly as unclaimed space (R3).
- R9: `rsp_rdata` and `rsp_err` equal the selected target's read data and error inputs in the same cycle.
- R10: No select output is high while `req_valid`=0, and at most one is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only for the embedded checks |
| rst_n | input | 1 | Active-low reset, gates the embedded checks |
| sec_ext_en | input | 1 | Enables the alias windows |
| req_valid | input | 1 | Access present this cycle |
| req_addr | input | 20 | Offset within the peripheral space |
| req_size | input | 2 | Access size code, passed through |
| req_write | input | 1 | 1 = write |
| req_wdata | input | 32 | Write data |
| req_secure | input | 1 | Secure attribute |
| req_priv | input | 1 | 1 = privileged, 0 = user |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Bus error |
| sel_sys | output | 1 | System-register block select |
| sel_tmr_s | output | 1 | Secure timer bank select |
| sel_tmr_ns | output | 1 | Non-secure timer bank select |
| sel_errblk | output | 1 | Error-reporting block select |
| tgt_addr | output | 12 | Offset within the selected target |
| tgt_size | output | 2 | Forwarded size |
| tgt_write | output | 1 | Forwarded write flag |
| tgt_wdata | output | 32 | Forwarded write data |
| tgt_secure | output | 1 | Forwarded secure attribute after alias rewrite |
| sys_rdata | input | 32 | System-register block read data |
| sys_err | input | 1 | System-register block error |
| tmr_s_rdata | input | 32 | Secure timer read data |
| tmr_s_err | input | 1 | Secure timer error |
| tmr_ns_rdata | input | 32 | Non-secure timer read data |
| tmr_ns_err | input | 1 | Non-secure timer error |
| errblk_rdata | input | 32 | Error block read data |
| errblk_err | input | 1 | Error block error |

## Verification
The hardest case is the timer alias. It needs the alias enable, a secure attribute and an offset inside a 0xE0-byte window of one specific page, all at once, and only then must the access land on the non-secure bank with its attribute cleared. Uniform random addresses almost never hit that window. The stimulus therefore picks region pages and window edges by weighted choice, and randomises the enable, security and privilege bits independently. Directed accesses cover both edges of each window, the pages next to the error block, and the alias page with the enable low.

// File: rtl/ppb_router.sv
module ppb_router #(
  parameter int        AW          = 20,
  parameter int        DW          = 32,
  parameter int        OW          = 12,
  parameter bit        HAS_ERR_BLK = 1'b1,
  parameter bit [7:0]  SYS_PAGE    = 8'h0E,
  parameter bit [7:0]  ALIAS_PAGE  = 8'h2E,
  parameter bit [7:0]  ERR_PAGE    = 8'h05,
  parameter bit [11:0] TMR_LO      = 12'h010,
  parameter bit [11:0] TMR_HI      = 12'h0F0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_ext_en,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_secure,
  input  logic          req_priv,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic          sel_sys,
  output logic          sel_tmr_s,
  output logic          sel_tmr_ns,
  output logic          sel_errblk,
  output logic [OW-1:0] tgt_addr,
  output logic [1:0]    tgt_size,
  output logic          tgt_write,
  output logic [DW-1:0] tgt_wdata,
  output logic          tgt_secure,
  input  logic [DW-1:0] sys_rdata,
  input  logic          sys_err,
  input  logic [DW-1:0] tmr_s_rdata,
  input  logic          tmr_s_err,
  input  logic [DW-1:0] tmr_ns_rdata,
  input  logic          tmr_ns_err,
  input  logic [DW-1:0] errblk_rdata,
  input  logic          errblk_err
);
  localparam int PW = AW - OW;

  logic [PW-1:0] page;
  logic [OW-1:0] poff;
  logic          in_win, on_sys, on_alias, on_err;
  logic          alias_fwd, alias_local, tmr_hit, eff_secure;

  assign page = req_addr[AW-1:OW];
  assign poff = req_addr[OW-1:0];

  assign in_win   = (poff >= TMR_LO) && (poff < TMR_HI);
  assign on_sys   = (page == PW'(SYS_PAGE));
  assign on_alias = sec_ext_en && (page == PW'(ALIAS_PAGE));

  generate
    if (HAS_ERR_BLK) begin : g_err
      assign on_err = (page == PW'(ERR_PAGE));
    end else begin : g_no_err
      assign on_err = 1'b0;
    end
  endgenerate

  assign alias_fwd   = on_alias && req_secure;
  assign alias_local = on_alias && !req_secure;
  assign tmr_hit     = in_win && (on_sys || alias_fwd);
  assign eff_secure  = on_alias ? 1'b0 : req_secure;

  assign sel_tmr_s  = req_valid && tmr_hit && eff_secure;
  assign sel_tmr_ns = req_valid && tmr_hit && !eff_secure;
  assign sel_sys    = req_valid && !tmr_hit && (on_sys || alias_fwd);
  assign sel_errblk = req_valid && on_err;

  assign tgt_addr   = tmr_hit ? (poff - TMR_LO) : poff;
  assign tgt_size   = req_size;
  assign tgt_write  = req_write;
  assign tgt_wdata  = req_wdata;
  assign tgt_secure = eff_secure;

  always_comb begin
    rsp_rdata = '0;
    rsp_err   = 1'b0;
    unique case (1'b1)
      sel_sys:    begin rsp_rdata = sys_rdata;    rsp_err = sys_err;    end
      sel_tmr_s:  begin rsp_rdata = tmr_s_rdata;  rsp_err = tmr_s_err;  end
      sel_tmr_ns: begin rsp_rdata = tmr_ns_rdata; rsp_err = tmr_ns_err; end
      sel_errblk: begin rsp_rdata = errblk_rdata; rsp_err = errblk_err; end
      default:    begin rsp_rdata = '0;           rsp_err = req_valid && !req_priv; end
    endcase
  end

  // R10
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_sys, sel_tmr_s, sel_tmr_ns, sel_errblk}));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(sel_sys || sel_tmr_s || sel_tmr_ns || sel_errblk));

  // R3
  user_default_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_priv && !(sel_sys || sel_tmr_s || sel_tmr_ns || sel_errblk))
      |-> (rsp_err && rsp_rdata == '0));

  // R6
  alias_clears_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && on_alias) |-> !(sel_tmr_s || tgt_secure));

  // R7
  ns_alias_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && alias_local) |-> !(sel_sys || sel_tmr_s || sel_tmr_ns || sel_errblk));

  // R2
  tmr_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_tmr_s || sel_tmr_ns) |-> (tgt_addr < (TMR_HI - TMR_LO)));
endmodule

// File: tb/ppb_router_tb.sv
module ppb_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_ext_en = 1'b0;
  logic        req_valid = 1'b0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        req_secure = 1'b0;
  logic        req_priv = 1'b1;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        sel_sys, sel_tmr_s, sel_tmr_ns, sel_errblk;
  logic [11:0] tgt_addr;
  logic [1:0]  tgt_size;
  logic        tgt_write;
  logic [31:0] tgt_wdata;
  logic        tgt_secure;
  logic [31:0] sys_rdata = '0, tmr_s_rdata = '0, tmr_ns_rdata = '0, errblk_rdata = '0;
  logic        sys_err = 1'b0, tmr_s_err = 1'b0, tmr_ns_err = 1'b0, errblk_err = 1'b0;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ppb_router u_dut (
    .clk(clk), .rst_n(rst_n), .sec_ext_en(sec_ext_en), .req_valid(req_valid),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .req_secure(req_secure), .req_priv(req_priv),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .sel_sys(sel_sys),
    .sel_tmr_s(sel_tmr_s), .sel_tmr_ns(sel_tmr_ns), .sel_errblk(sel_errblk),
    .tgt_addr(tgt_addr), .tgt_size(tgt_size), .tgt_write(tgt_write),
    .tgt_wdata(tgt_wdata), .tgt_secure(tgt_secure),
    .sys_rdata(sys_rdata), .sys_err(sys_err), .tmr_s_rdata(tmr_s_rdata),
    .tmr_s_err(tmr_s_err), .tmr_ns_rdata(tmr_ns_rdata), .tmr_ns_err(tmr_ns_err),
    .errblk_rdata(errblk_rdata), .errblk_err(errblk_err)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s addr=%05h actual=%0h expected=%0h", tag, what, req_addr, act, exp);
    end
  endtask

  // expected selects {errblk, tmr_ns, tmr_s, sys}
  task automatic model(input logic [19:0] a, input logic sec, input logic pv, input logic en,
                       output logic [3:0] esel, output logic [11:0] eaddr, output logic esec,
                       output string tag);
    logic [11:0] off;
    logic        win;
    off = a[11:0];
    win = (off >= 12'h010) && (off <= 12'h0EF);
    esel = 4'b0000; eaddr = off; esec = sec; tag = "R3";
    if (a[19:12] == 8'h0E) begin
      if (win) begin esel = sec ? 4'b0010 : 4'b0100; eaddr = off - 12'h010; tag = "R2"; end
      else begin esel = 4'b0001; tag = "R1"; end
    end else if (a[19:12] == 8'h05) begin
      esel = 4'b1000; tag = "R4";
    end else if (a[19:12] == 8'h2E) begin
      if (!en) tag = "R8";
      else if (!sec) tag = "R7";
      else begin
        esec = 1'b0;
        if (win) begin esel = 4'b0100; eaddr = off - 12'h010; tag = "R6"; end
        else begin esel = 4'b0001; tag = "R5"; end
      end
    end
    if (!pv && esel == 4'b0000) tag = {tag, "/user"};
  endtask

  task automatic access(input logic [19:0] a, input logic sec, input logic pv, input logic en, input logic wr);
    logic [3:0]  esel;
    logic [11:0] eaddr;
    logic        esec;
    string       tag;
    logic [31:0] erd;
    logic        eer;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_secure = sec; req_priv = pv; sec_ext_en = en;
    req_write = wr; req_wdata = $urandom; req_size = 2'($urandom_range(0, 2));
    sys_rdata = $urandom; tmr_s_rdata = $urandom; tmr_ns_rdata = $urandom; errblk_rdata = $urandom;
    sys_err = 1'($urandom); tmr_s_err = 1'($urandom); tmr_ns_err = 1'($urandom); errblk_err = 1'($urandom);
    #2;
    model(a, sec, pv, en, esel, eaddr, esec, tag);
    case (esel)
      4'b0001: begin erd = sys_rdata;    eer = sys_err;    end
      4'b0010: begin erd = tmr_s_rdata;  eer = tmr_s_err;  end
      4'b0100: begin erd = tmr_ns_rdata; eer = tmr_ns_err; end
      4'b1000: begin erd = errblk_rdata; eer = errblk_err; end
      default: begin erd = '0;           eer = !pv;        end
    endcase
    check(tag, "select", {28'd0, sel_errblk, sel_tmr_ns, sel_tmr_s, sel_sys}, {28'd0, esel});
    check(esel != 0 ? {tag, "/R9"} : tag, "rdata", rsp_rdata, erd);
    check(esel != 0 ? {tag, "/R9"} : tag, "err", {31'd0, rsp_err}, {31'd0, eer});
    if (esel != 0) begin
      check(tag, "tgt_addr", {20'd0, tgt_addr}, {20'd0, eaddr});
      check(tag, "tgt_secure", {31'd0, tgt_secure}, {31'd0, esec});
      check(tag, "tgt_write", {31'd0, tgt_write}, {31'd0, wr});
      check(tag, "tgt_wdata", tgt_wdata, req_wdata);
    end
  endtask

  function automatic logic [19:0] pick_addr();
    logic [11:0] off;
    logic [7:0]  pg;
    case ($urandom_range(0, 5))
      0: pg = 8'h0E;
      1: pg = 8'h2E;
      2: pg = 8'h05;
      3: pg = 8'($urandom_range(0, 255));
      4: pg = 8'h0E;
      default: pg = 8'h2E;
    endcase
    case ($urandom_range(0, 3))
      0: off = 12'($urandom_range(12'h000, 12'h0FF));
      1: off = 12'(($urandom_range(0, 3) == 0) ? 12'h010 : 12'h0EF) + 12'($urandom_range(0, 1)) - 12'($urandom_range(0, 1));
      default: off = 12'($urandom);
    endcase
    return {pg, off};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2;
    // R10 reset/idle: no select while idle
    check("R10", "idle select", {28'd0, sel_errblk, sel_tmr_ns, sel_tmr_s, sel_sys}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    req_addr = 20'h0E010; req_secure = 1'b1; sec_ext_en = 1'b1;
    #2;
    check("R10", "invalid select", {28'd0, sel_errblk, sel_tmr_ns, sel_tmr_s, sel_sys}, 32'd0);
    check("R10", "invalid err", {31'd0, rsp_err}, 32'd0);

    // directed boundaries
    access(20'h0E000, 1'b1, 1'b1, 1'b0, 1'b0);  // R1
    access(20'h0E00F, 1'b0, 1'b0, 1'b0, 1'b1);  // R1
    access(20'h0E010, 1'b1, 1'b0, 1'b0, 1'b0);  // R2 secure bank
    access(20'h0E0EF, 1'b0, 1'b1, 1'b0, 1'b1);  // R2 non-secure bank
    access(20'h0E0F0, 1'b1, 1'b1, 1'b0, 1'b0);  // R1
    access(20'h0EFFF, 1'b0, 1'b1, 1'b0, 1'b0);  // R1
    access(20'h0F000, 1'b1, 1'b1, 1'b0, 1'b1);  // R3 privileged
    access(20'h0F000, 1'b1, 1'b0, 1'b0, 1'b0);  // R3 user
    access(20'h05000, 1'b0, 1'b1, 1'b0, 1'b0);  // R4
    access(20'h05FFF, 1'b1, 1'b0, 1'b0, 1'b1);  // R4
    access(20'h04FFF, 1'b1, 1'b0, 1'b0, 1'b0);  // R3
    access(20'h06000, 1'b1, 1'b1, 1'b0, 1'b0);  // R3
    access(20'h2E000, 1'b1, 1'b1, 1'b1, 1'b1);  // R5
    access(20'h2E010, 1'b1, 1'b0, 1'b1, 1'b0);  // R6
    access(20'h2E0EF, 1'b1, 1'b1, 1'b1, 1'b1);  // R6
    access(20'h2E0F0, 1'b1, 1'b1, 1'b1, 1'b0);  // R5
    access(20'h2E010, 1'b0, 1'b1, 1'b1, 1'b1);  // R7 privileged write ignored
    access(20'h2E800, 1'b0, 1'b0, 1'b1, 1'b0);  // R7 user
    access(20'h2E010, 1'b1, 1'b1, 1'b0, 1'b0);  // R8
    access(20'h2E400, 1'b1, 1'b0, 1'b0, 1'b1);  // R8

    for (int i = 0; i < 3000; i++)
      access(pick_addr(), 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) != 0), 1'($urandom));

    @(negedge clk);
    req_valid = 1'b0;
    #2;
    check("R10", "final idle select", {28'd0, sel_errblk, sel_tmr_ns, sel_tmr_s, sel_sys}, 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule